// File: doc/BRIEF.md
# Auto-Ranging Gated Frequency Counter

This block measures the frequency of an asynchronous pulse input by counting its rising edges during a gate window. The window is timed in ticks of a reference time base. A short gate of `SHORT_TICKS` ticks is the default. Edges are counted by three ripple-connected stages clocked by the input itself: a narrow fast stage, a wide middle stage and an extension stage that counts wraps of the middle stage. Together they form one binary word. When the gate closes the stages freeze. The frozen word is copied into the reference clock domain a few ticks later and is then delivered with a one-cycle strobe and a flag that tells which gate produced it. The stages are then held in clear until shortly before the next gate opens.

The block repeats its frame on a fixed schedule. A frame has one gate followed by a pause long enough to skip one whole gate period, so with the default numbers a short-gate result appears every 320 ticks. The block also picks its range automatically. If a short-gate result is non-zero and has no more than `SMALL_DIGITS` decimal digits, the next frame uses a gate `LONG_MULT` times longer, which gives one more significant digit. After a long-gate result, the block always goes back to the short gate.

Top module: `freq_gate_counter`

## Requirements
- R1: With `tick` high every cycle, a short gate is open for exactly `SHORT_TICKS` clock cycles and a long gate for exactly `SHORT_TICKS*LONG_MULT` cycles. With ticks every M cycles, both lengths are multiplied by M. Input edges outside the open gate are not counted.
- R2: `result` is the exact number of counted edges. Bits [PRE_W-1:0] come from the fast stage, the next MID_W bits from the middle stage, and the top EXT_W bits count middle-stage wraps. The frozen count still equals `result` while `result_valid` is high.
- R3: A short-gate result that is non-zero and below 10^SMALL_DIGITS makes the next frame use the long gate, and that result carries `long_mode` = 1. The mode changes only at a frame boundary.
- R4: A short-gate result of zero leaves the next frame on the short gate.
- R5: A long-gate result is always followed by a short-gate frame.
- R6: `result_valid` is high for exactly one cycle per frame, and only while the gate is closed.
- R7: Consecutive strobes are spaced by the span of the earlier frame plus the difference of the two gate lengths, counted in ticks. A short frame spans 2·PERIOD_TICKS ticks. A long frame spans long gate + 2·PERIOD_TICKS − SHORT_TICKS ticks. Two short results are therefore 320 ticks apart with the defaults.
- R8: A short-gate result of exactly 10^SMALL_DIGITS stays on the short gate.
- R9: During reset `result` is zero, `result_valid` is low and `long_mode` is low.
- R10: Counting is enabled only while the gate is open and the stage clear is released. The gate is never open while the clear is applied. The stages read zero when the clear is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base enable, one pulse per gate time unit |
| sig_in | input | 1 | Asynchronous input whose rising edges are counted |
| result | output | PRE_W+MID_W+EXT_W | Frozen edge count of the last frame |
| result_valid | output | 1 | One-cycle strobe marking a new result |
| long_mode | output | 1 | 0 when the result came from the short gate, 1 from the long gate |

## Verification
The hardest state to reach from the ports is a wrap of the middle stage into the extension stage, because that needs more than a million input edges inside one gate. The stimulus gets there by slowing the tick to one per four cycles, which stretches the gate to 400 cycles, and by packing thousands of 2 ps pulses into each clock period well clear of the clock edges. The same pulse train gives exact expected counts for the range boundaries just below and at 10^4. A scoreboard follows the short, long, short sequence of modes frame by frame.

// File: rtl/fg_pkg.sv
`timescale 1ns/1ps
package fg_pkg;

  // Compute 10^n as a 64-bit value.
  function automatic logic [63:0] pow10(input int n);
    logic [63:0] p;
    p = 64'd1;
    for (int i = 0; i < n; i++) p = p * 64'd10;
    return p;
  endfunction

  // A count qualifies for the long gate when it is non-zero and below the limit.
  function automatic logic fg_small(input logic [63:0] v, input logic [63:0] lim);
    return (v != 64'd0) && (v < lim);
  endfunction

endpackage

// File: rtl/fg_stage.sv
`timescale 1ns/1ps
module fg_stage #(
  parameter int W = 4
) (
  input  logic         cnt_clk,
  input  logic         clr_n,
  input  logic         inc,
  output logic [W-1:0] val,
  output logic         carry
);

  always_ff @(posedge cnt_clk or negedge clr_n) begin
    if (!clr_n)   val <= '0;
    else if (inc) val <= val + 1'b1;
  end

  assign carry = inc & (&val);

endmodule

// File: rtl/fg_count_chain.sv
`timescale 1ns/1ps
module fg_count_chain #(
  parameter int PRE_W = 4,
  parameter int MID_W = 16,
  parameter int EXT_W = 5,
  localparam int RES_W = PRE_W + MID_W + EXT_W
) (
  input  logic             cnt_clk,
  input  logic             clr_n,
  input  logic             en,
  output logic [RES_W-1:0] count,
  output logic             ovf
);

  localparam int NST = 3;

  function automatic int sw(input int i);
    case (i)
      0:       return PRE_W;
      1:       return MID_W;
      default: return EXT_W;
    endcase
  endfunction

  function automatic int so(input int i);
    case (i)
      0:       return 0;
      1:       return PRE_W;
      default: return PRE_W + MID_W;
    endcase
  endfunction

  logic [NST:0] cy;
  assign cy[0] = en;

  for (genvar i = 0; i < NST; i++) begin : g_st
    fg_stage #(.W(sw(i))) u_stage (
      .cnt_clk (cnt_clk),
      .clr_n   (clr_n),
      .inc     (cy[i]),
      .val     (count[so(i) +: sw(i)]),
      .carry   (cy[i+1])
    );
  end

  assign ovf = cy[NST];

endmodule

// File: rtl/fg_frame_seq.sv
`timescale 1ns/1ps
module fg_frame_seq #(
  parameter int SHORT_T  = 100,
  parameter int PERIOD_T = 160,
  parameter int LONG_T   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic go_long,
  output logic gate_o,
  output logic clr_n_o,
  output logic cap_o,
  output logic wrap_o,
  output logic long_o,
  output logic pend_o
);

  localparam int SPAN_S = 2 * PERIOD_T;
  localparam int SPAN_L = LONG_T + 2 * PERIOD_T - SHORT_T;
  localparam int TW     = $clog2(SPAN_L + 1);

  localparam logic [TW-1:0] GL_S   = TW'(SHORT_T);
  localparam logic [TW-1:0] GL_L   = TW'(LONG_T);
  localparam logic [TW-1:0] LAST_S = TW'(SPAN_S - 1);
  localparam logic [TW-1:0] LAST_L = TW'(SPAN_L - 1);

  function automatic logic [TW-1:0] pick(input logic l, input logic [TW-1:0] a,
                                         input logic [TW-1:0] b);
    return l ? b : a;
  endfunction

  logic [TW-1:0] tcnt, nx_tcnt, glen_c, last_c, glen_n, last_n;
  logic          long_q, pend_q, gate_q, clr_q, nx_long, wrap, cap;

  assign glen_c  = pick(long_q, GL_S, GL_L);
  assign last_c  = pick(long_q, LAST_S, LAST_L);
  assign wrap    = tick && (tcnt == last_c);
  assign cap     = tick && (tcnt == glen_c + TW'(2));
  assign nx_long = wrap ? pend_q : long_q;
  assign nx_tcnt = !tick ? tcnt : (wrap ? '0 : tcnt + 1'b1);
  assign glen_n  = pick(nx_long, GL_S, GL_L);
  assign last_n  = pick(nx_long, LAST_S, LAST_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt   <= LAST_S - 1'b1;
      long_q <= 1'b0;
      pend_q <= 1'b0;
      gate_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      tcnt   <= nx_tcnt;
      long_q <= nx_long;
      if (cap) pend_q <= go_long;
      gate_q <= (nx_tcnt < glen_n);
      clr_q  <= !((nx_tcnt >= glen_n + TW'(5)) && (nx_tcnt < last_n));
    end
  end

  assign gate_o  = gate_q;
  assign clr_n_o = clr_q;
  assign cap_o   = cap;
  assign wrap_o  = wrap;
  assign long_o  = long_q;
  assign pend_o  = pend_q;

endmodule

// File: rtl/freq_gate_counter.sv
`timescale 1ns/1ps
module freq_gate_counter #(
  parameter int PRE_W        = 4,
  parameter int MID_W        = 16,
  parameter int EXT_W        = 5,
  parameter int SHORT_TICKS  = 100,
  parameter int PERIOD_TICKS = 160,
  parameter int LONG_MULT    = 10,
  parameter int SMALL_DIGITS = 4,
  localparam int RES_W       = PRE_W + MID_W + EXT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sig_in,
  output logic [RES_W-1:0] result,
  output logic             result_valid,
  output logic             long_mode
);

  localparam int          LONG_TICKS = SHORT_TICKS * LONG_MULT;
  localparam logic [63:0] SMALL_LIM  = fg_pkg::pow10(SMALL_DIGITS);

  // Named internal events, also used by the bound checker.
  logic             gate_on, clr_n, cap_evt, wrap_evt, long_q, pend_long;
  logic             cnt_en, chain_ovf, go_long;
  logic [RES_W-1:0] count_live;
  logic [RES_W-1:0] res_q;
  logic             val_q, mode_q;

  fg_frame_seq #(
    .SHORT_T  (SHORT_TICKS),
    .PERIOD_T (PERIOD_TICKS),
    .LONG_T   (LONG_TICKS)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .go_long (go_long),
    .gate_o  (gate_on),
    .clr_n_o (clr_n),
    .cap_o   (cap_evt),
    .wrap_o  (wrap_evt),
    .long_o  (long_q),
    .pend_o  (pend_long)
  );

  assign cnt_en = gate_on & clr_n;

  fg_count_chain #(
    .PRE_W (PRE_W),
    .MID_W (MID_W),
    .EXT_W (EXT_W)
  ) u_chain (
    .cnt_clk (sig_in),
    .clr_n   (clr_n),
    .en      (cnt_en),
    .count   (count_live),
    .ovf     (chain_ovf)
  );

  // The count has been frozen for at least two ticks when cap_evt fires.
  assign go_long = !long_q && fg_pkg::fg_small(64'(count_live), SMALL_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      val_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      val_q <= cap_evt;
      if (cap_evt) begin
        res_q  <= count_live;
        mode_q <= long_q;
      end
    end
  end

  assign result       = res_q;
  assign result_valid = val_q;
  assign long_mode    = mode_q;

endmodule

// File: rtl/fg_checker.sv
`timescale 1ns/1ps
module fg_checker #(
  parameter int RES_W = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_on,
  input logic             clr_n,
  input logic             wrap_evt,
  input logic             long_q,
  input logic             pend_long,
  input logic             chain_ovf,
  input logic [RES_W-1:0] count_live,
  input logic [RES_W-1:0] result,
  input logic             result_valid,
  input logic             long_mode
);

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R6
  valid_gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> !gate_on);

  // R10
  gate_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |-> clr_n);

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_n) |-> (count_live == '0));

  // R2
  frozen_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (result == count_live));

  // R2
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_ovf);

  // R3
  mode_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(long_q) |-> $past(wrap_evt));

  // R5
  long_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && long_mode) |-> !pend_long);

  // R4
  zero_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && result == '0) |-> !pend_long);

endmodule

bind freq_gate_counter fg_checker #(.RES_W(RES_W)) u_fg_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .gate_on      (gate_on),
  .clr_n        (clr_n),
  .wrap_evt     (wrap_evt),
  .long_q       (long_q),
  .pend_long    (pend_long),
  .chain_ovf    (chain_ovf),
  .count_live   (count_live),
  .result       (result),
  .result_valid (result_valid),
  .long_mode    (long_mode)
);

// File: tb/test_freq_gate_counter.sv
`timescale 1ns/1ps
module test_freq_gate_counter;

  localparam time CLK_PERIOD = 10ns;
  localparam int  SHORT_G  = 100;
  localparam int  LONG_G   = 1000;
  localparam int  SPAN_S   = 320;
  localparam int  SPAN_L   = 1220;
  localparam int  RES_W    = 25;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b1;
  logic             sig_in = 1'b0;
  logic [RES_W-1:0] result;
  logic             result_valid;
  logic             long_mode;

  freq_gate_counter i_freq_gate_counter (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .sig_in       (sig_in),
    .result       (result),
    .result_valid (result_valid),
    .long_mode    (long_mode)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    total = 0;
  int    bad = 0;
  int    pulses_per_cyc = 0;
  int    tick_div = 1;
  longint cyc = 0;
  int    popped = 0;
  time   t_last = 0;
  time   t_prev = 0;
  bit    prev_valid = 1'b0;

  typedef struct { longint val; bit lng; string tag; } exp_t;
  exp_t q[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Time base: one tick every tick_div cycles.
  always @(negedge clk) begin
    cyc++;
    tick = ((cyc % tick_div) == 0);
  end

  // Input pulses: a burst of 2 ps pulses starting 1 ns after each rising clock edge.
  initial begin
    forever begin
      @(posedge clk);
      #1ns;
      begin
        int n;
        n = pulses_per_cyc;
        for (int i = 0; i < n; i++) begin
          sig_in = 1'b1; #1ps;
          sig_in = 1'b0; #1ps;
        end
      end
    end
  end

  // Monitor: pop expected items as strobes appear.
  always @(negedge clk) begin
    if (rst_n) begin
      if (result_valid) begin
        check(!prev_valid, "R6 strobe width", 2, 1);
        if (q.size() == 0) begin
          check(1'b0, "R6 unexpected result", longint'(result), -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(longint'(result) == e.val, {e.tag, " value"}, longint'(result), e.val);
          check(long_mode == e.lng, {e.tag, " mode"}, longint'(long_mode), longint'(e.lng));
        end
        t_prev = t_last;
        t_last = $time;
        popped++;
      end
      prev_valid = result_valid;
    end
  end

  // Scoreboard model of the range selection.
  bit model_long = 1'b0;

  task automatic expect_frames(input int p, input int m, input int n, input string tag);
    bit prev_lng;
    pulses_per_cyc = p;
    tick_div = m;
    prev_lng = 1'b0;
    for (int k = 0; k < n; k++) begin
      exp_t e;
      int target;
      longint gap_exp;
      e.lng = model_long;
      e.val = longint'(p) * m * (model_long ? LONG_G : SHORT_G);
      e.tag = tag;
      q.push_back(e);
      target = popped + 1;
      wait (popped == target);
      if (k > 0) begin
        // R7: spacing of strobes in ticks scaled to cycles
        gap_exp = longint'((prev_lng ? SPAN_L : SPAN_S)
                  + (e.lng ? LONG_G : SHORT_G) - (prev_lng ? LONG_G : SHORT_G)) * m;
        check((t_last - t_prev) / CLK_PERIOD == gap_exp, "R7 strobe spacing",
              longint'((t_last - t_prev) / CLK_PERIOD), gap_exp);
      end
      prev_lng = e.lng;
      // R3 R4 R5 R8: next mode
      model_long = !model_long && (e.val != 0) && (e.val < 10000);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    check(result == '0, "R9 result", longint'(result), 0);
    check(!result_valid, "R9 valid", longint'(result_valid), 0);
    check(!long_mode, "R9 mode", longint'(long_mode), 0);
    rst_n = 1'b1;

    // R4: zero input stays on the short gate
    expect_frames(0, 1, 2, "R4 zero");
    // R1 R3 R5: small count alternates short and long gates
    expect_frames(1, 1, 4, "R3 R5 small");
    // R3: largest small value, long gate stays below 10^5
    expect_frames(99, 1, 2, "R3 edge");
    // R8: exactly 10^4 stays short
    expect_frames(100, 1, 2, "R8 boundary");
    // R1: slower tick stretches the gate
    expect_frames(37, 3, 1, "R1 tick spacing");
    // R2: count beyond the middle stage reaches the extension bits
    expect_frames(2700, 4, 1, "R2 extension");
    pulses_per_cyc = 0;

    repeat (5) @(negedge clk);
    check(q.size() == 0, "R6 pending items", longint'(q.size()), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule